// File: doc/BRIEF.md
# NAND Page Address Cycle Sequencer

This block turns a page index and a column offset into the ordered run of address bytes that follow a command byte on a NAND flash bus. It supports two device geometries. Small pages hold 512 data bytes and 16 spare bytes, 528 in all. Large pages hold four small pages, which is 2048 data bytes and 64 spare bytes. Each geometry has a short and a long addressing form. Small-page parts take 3 address cycles, or 4 with the extra-cycle option. Large-page parts take 4 cycles, or 5 with the option. Small-page parts have 32 pages per block, and large-page parts have 64 or 128. The bus may be 8 or 16 bits wide. On a 16-bit bus the column counts words, so the block halves the column before emitting it.

A single start pulse captures the page, the column and the three mode bits. The block then presents bytes one at a time on a valid/ready stream to a downstream strobe generator, and it marks the final byte with a last flag. The column bytes come first: one for small pages, two for large pages. The second large-page column byte carries column bits 11..8 with its upper four bits zero. The page-index bytes follow, least significant byte first. While a sequence is running, the block ignores further start pulses.

The state machine has three states. ST_IDLE means no sequence is active. ST_COL emits the column bytes, and ST_ROW emits the page-index bytes. It has five transitions. T_LAUNCH goes from ST_IDLE to ST_COL on start. T_COL_NEXT stays in ST_COL when a column byte is accepted and more column bytes remain. T_TO_ROW goes from ST_COL to ST_ROW when the last column byte is accepted. T_ROW_NEXT stays in ST_ROW when a page byte is accepted and more remain. T_FINISH goes from ST_ROW to ST_IDLE when the final byte is accepted.

Top module: `nas_addr_seq`

## Requirements
- R1: While reset is active and after it is released, `valid_o` and `last_o` are low until a start is accepted.
- R2: A start pulse seen in the idle state captures all inputs, and the first byte is valid on the next cycle.
- R3: With large=0 and extra=0, exactly 3 bytes are sent: column[7:0], page[7:0], page[15:8].
- R4: With large=0 and extra=1, exactly 4 bytes are sent: column[7:0], page[7:0], page[15:8], page[23:16].
- R5: With large=1 and extra=0, exactly 4 bytes are sent: column[7:0], {4'h0, column[11:8]}, page[7:0], page[15:8].
- R6: With large=1 and extra=1, exactly 5 bytes are sent: the four bytes of R5, then page[23:16].
- R7: With bus16=1, the emitted column is the input column shifted right by one bit, and the byte layout is the same as in R3 to R6.
- R8: While valid is high and ready is low, the byte and the last flag hold steady, and the sequence advances only on a cycle with valid and ready both high.
- R9: `last_o` is high only together with the final byte of a sequence, and valid is low on the cycle after that byte is accepted.
- R10: A start seen while a sequence is active is ignored. This includes the cycle in which the final byte is accepted. Input changes after capture do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| page_i | input | 24 | Page index |
| col_i | input | 12 | Column offset in bytes |
| large_i | input | 1 | 1 selects the large-page layout |
| extra_i | input | 1 | 1 adds the extra page-index cycle |
| bus16_i | input | 1 | 1 selects a 16-bit bus (column halved) |
| ready_i | input | 1 | Downstream accepts the current byte |
| valid_o | output | 1 | Byte on `byte_o` is valid |
| byte_o | output | 8 | Address byte |
| last_o | output | 1 | Final byte of the sequence |

## Verification
Two events can land on the same cycle: the downstream acceptance of the final byte, and a new start request. The bench holds start high with altered page and column values from just after capture until the end of the sequence, so start is also high on the closing handshake. It then checks that the bytes match the originally captured values and that valid stays low on the two following cycles. A second overlap, a stall on ready at a column/page segment boundary, is provoked by toggling ready on each cycle. It is judged by comparing each held byte with the byte seen on the previous cycle.

// File: rtl/nas_pkg.sv
package nas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COL  = 2'd1,
        ST_ROW  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [1:0] col_n;
        logic [1:0] row_n;
    } layout_t;
endpackage

// File: rtl/nas_layout.sv
module nas_layout
    import nas_pkg::*;
(
    input  logic    large_i,
    input  logic    extra_i,
    output layout_t layout_o
);
    // Column bytes depend on page size; the extra cycle always lengthens the page index.
    always_comb begin
        layout_o.col_n = large_i ? 2'd2 : 2'd1;
        layout_o.row_n = extra_i ? 2'd3 : 2'd2;
    end
endmodule

// File: rtl/nas_byte_mux.sv
module nas_byte_mux #(
    parameter int PAGE_W = 24,
    parameter int COL_W  = 12
) (
    input  logic              seg_row_i,
    input  logic [1:0]        idx_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [7:0]        byte_o
);
    localparam int PAGE_BYTES = (PAGE_W + 7) / 8;
    localparam int COL_BYTES  = (COL_W + 7) / 8;

    logic [PAGE_BYTES*8-1:0] page_pad;
    logic [COL_BYTES*8-1:0]  col_pad;
    logic [7:0] page_b [PAGE_BYTES];
    logic [7:0] col_b  [COL_BYTES];

    always_comb begin
        page_pad = '0;
        page_pad[PAGE_W-1:0] = page_i;
        col_pad = '0;
        col_pad[COL_W-1:0] = col_i;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
        assign page_b[g] = page_pad[g*8 +: 8];
    end
    for (genvar g = 0; g < COL_BYTES; g++) begin : g_col
        assign col_b[g] = col_pad[g*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        if (seg_row_i) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                if (int'(idx_i) == b) byte_o = page_b[b];
        end else begin
            for (int b = 0; b < COL_BYTES; b++)
                if (int'(idx_i) == b) byte_o = col_b[b];
        end
    end
endmodule

// File: rtl/nas_ctrl.sv
module nas_ctrl
    import nas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ready_i,
    input  layout_t    layout_i,
    output logic       load_o,
    output logic       valid_o,
    output logic       last_o,
    output logic       seg_row_o,
    output logic [1:0] idx_o
);
    seq_state_t state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic       take;
    logic       col_end, row_end;

    assign take    = valid_o && ready_i;
    assign col_end = (idx_q == layout_i.col_n - 2'd1);
    assign row_end = (idx_q == layout_i.row_n - 2'd1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin            // T_LAUNCH
                    state_d = ST_COL;
                    idx_d   = 2'd0;
                end
            end
            ST_COL: begin
                if (take) begin
                    if (col_end) begin        // T_TO_ROW
                        state_d = ST_ROW;
                        idx_d   = 2'd0;
                    end else begin            // T_COL_NEXT
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
            ST_ROW: begin
                if (take) begin
                    if (row_end) begin        // T_FINISH
                        state_d = ST_IDLE;
                        idx_d   = 2'd0;
                    end else begin            // T_ROW_NEXT
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = 2'd0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        load_o    = (state_q == ST_IDLE) && start_i;
        valid_o   = (state_q != ST_IDLE);
        seg_row_o = (state_q == ST_ROW);
        last_o    = (state_q == ST_ROW) && row_end;
        idx_o     = idx_q;
    end
endmodule

// File: rtl/nas_addr_seq.sv
module nas_addr_seq
    import nas_pkg::*;
#(
    parameter int PAGE_W = 24,
    parameter int COL_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              large_i,
    input  logic              extra_i,
    input  logic              bus16_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [7:0]        byte_o,
    output logic              last_o
);
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic              large_q, extra_q;
    logic              load, seg_row;
    logic [1:0]        idx;
    layout_t           layout;

    // Capture on accepted start; column is halved on a word-wide bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            col_q   <= '0;
            large_q <= 1'b0;
            extra_q <= 1'b0;
        end else if (load) begin
            page_q  <= page_i;
            col_q   <= bus16_i ? (col_i >> 1) : col_i;
            large_q <= large_i;
            extra_q <= extra_i;
        end
    end

    nas_layout u_layout (
        .large_i  (large_q),
        .extra_i  (extra_q),
        .layout_o (layout)
    );

    nas_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ready_i   (ready_i),
        .layout_i  (layout),
        .load_o    (load),
        .valid_o   (valid_o),
        .last_o    (last_o),
        .seg_row_o (seg_row),
        .idx_o     (idx)
    );

    nas_byte_mux #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_mux (
        .seg_row_i (seg_row),
        .idx_i     (idx),
        .page_i    (page_q),
        .col_i     (col_q),
        .byte_o    (byte_o)
    );
endmodule

// File: rtl/nas_addr_seq_chk.sv
module nas_addr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       ready_i,
    input logic       valid_o,
    input logic [7:0] byte_o,
    input logic       last_o
);
    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> valid_o);

    // R2
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(start_i));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(byte_o) && $stable(last_o)));

    // R9
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R10
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> !valid_o);
endmodule

bind nas_addr_seq nas_addr_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (ready_i),
    .valid_o (valid_o),
    .byte_o  (byte_o),
    .last_o  (last_o)
);

// File: tb/nas_addr_seq_tb.sv
`timescale 1ns/1ps
module nas_addr_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] page_i = '0;
    logic [11:0] col_i = '0;
    logic        large_i = 1'b0, extra_i = 1'b0, bus16_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        valid_o, last_o;
    logic [7:0]  byte_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nas_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
        .col_i(col_i), .large_i(large_i), .extra_i(extra_i), .bus16_i(bus16_i),
        .ready_i(ready_i), .valid_o(valid_o), .byte_o(byte_o), .last_o(last_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_seq(input string tag, input logic [23:0] pg, input logic [11:0] cl,
                           input bit lg, input bit ex, input bit b16,
                           input bit stall, input bit poke);
        logic [7:0]  exp_b [5];
        logic [11:0] cv;
        int n, k, guard;
        bit held;
        logic [7:0] hb;
        logic hl;
        bit rdy;
        cv = b16 ? (cl >> 1) : cl;
        n = 0;
        exp_b[n++] = cv[7:0];
        if (lg) exp_b[n++] = {4'h0, cv[11:8]};
        exp_b[n++] = pg[7:0];
        exp_b[n++] = pg[15:8];
        if (ex) exp_b[n++] = pg[23:16];

        @(negedge clk);
        page_i = pg; col_i = cl; large_i = lg; extra_i = ex; bus16_i = b16;
        start_i = 1'b1; ready_i = 1'b0;
        @(negedge clk);
        start_i = poke;
        if (poke) begin
            page_i = ~pg; col_i = ~cl; large_i = ~lg; extra_i = ~ex; bus16_i = ~b16;
        end
        chk({tag, " R2 first valid"}, int'(valid_o), 1);
        k = 0; guard = 0; held = 0; hb = '0; hl = 1'b0;
        while (k < n && guard < 100) begin
            if (held) begin
                chk({tag, " R8 held byte"}, int'(byte_o), int'(hb));
                chk({tag, " R8 held last"}, int'(last_o), int'(hl));
            end
            chk({tag, " valid in sequence"}, int'(valid_o), 1);
            rdy = stall ? guard[0] : 1'b1;
            if (rdy) begin
                chk({tag, " byte"}, int'(byte_o), int'(exp_b[k]));
                chk({tag, " R9 last"}, int'(last_o), int'(k == n - 1));
                k++;
                held = 0;
            end else begin
                held = 1; hb = byte_o; hl = last_o;
            end
            ready_i = rdy;
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        chk({tag, " R9 valid drops"}, int'(valid_o), 0);
        @(negedge clk);
        chk({tag, " R10 no relaunch"}, int'(valid_o), 0);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 valid in reset", int'(valid_o), 0);
        chk("R1 last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        run_seq("R3 small",          24'h123456, 12'hABC, 0, 0, 0, 0, 0);
        run_seq("R4 small extra",    24'hC0FFEE, 12'h05A, 0, 1, 0, 0, 0);
        run_seq("R5 large",          24'h00BEEF, 12'h9A5, 1, 0, 0, 0, 0);
        run_seq("R6 large extra",    24'h7E3C81, 12'h812, 1, 1, 0, 0, 0);
        run_seq("R7 bus16 large",    24'h010203, 12'hFFF, 1, 1, 1, 0, 0);
        run_seq("R7 bus16 small",    24'hA5A5A5, 12'h1FE, 0, 0, 1, 0, 0);
        run_seq("R8 stall",          24'h5A6B7C, 12'h3C7, 1, 1, 0, 1, 0);
        run_seq("R8 stall small",    24'h0F0E0D, 12'h0FF, 0, 1, 0, 1, 0);
        run_seq("R10 start busy",    24'h246813, 12'h777, 1, 0, 0, 0, 1);
        run_seq("R10 busy stall",    24'h135790, 12'h222, 0, 0, 0, 1, 1);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule